// File: doc/BRIEF.md
# Input Error and Mute Supervisor

This block sits behind a recovered audio stream decoder and decides whether the decoded samples may reach the rest of the chip. It takes the decoder's lock indication and a once-per-sample word-clock tick, counts an unbroken run of word-clock periods with lock held, and only then declares the input qualified. Until that point, and whenever lock is lost, it raises an error flag, forces every audio channel to zero, and silences one gated clock output.

Two pins adjust this behaviour. A hold input makes the error flag sticky: once it is raised, it stays up until the fault has gone and the hold input has also been released. A mute input zeroes all audio channels at any time, whatever the error state. The hold, mute and lock inputs may be asynchronous; they pass through synchronisers into the master clock domain. Channel data is registered once on its way through the block.

Top module: `sup_err_mute`

## Requirements
- R1: After reset, `err_out` is 1, `qual_ok` is 0 and every bit of `dout` is 0.
- R2: `qual_ok` becomes 1 only after QUAL_PERIODS (default 3900) `frame_tick` pulses are seen while the synchronised lock stays high. `err_out` stays 1 for as long as `qual_ok` is 0.
- R3: When lock drops, `qual_ok` returns to 0 and the period count restarts from zero. A short lock loss therefore delays qualification by a full QUAL_PERIODS run counted from the moment lock returns.
- R4: With the hold input low, `err_out` follows the fault state. It falls to 0 within a few cycles of `qual_ok` becoming 1.
- R5: With the hold input high, `err_out` stays 1 after the fault clears. It falls only once the hold input is also low.
- R6: While `err_out` is 1, every channel of `dout` is 0.
- R7: While the synchronised mute input is 1, every channel of `dout` is 0, even when `err_out` is 0.
- R8: When `err_out` is 0 and mute is low, `dout` equals `din`, registered once after the synchronisers' delay has passed.
- R9: `gclk_out` is `src_clk` passed through a latch-based enable that is the inverse of the error flag. It gives no pulses while the error is set and one pulse per `src_clk` pulse while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_in | input | 1 | Decoder lock/valid indication, asynchronous |
| frame_tick | input | 1 | One-cycle pulse per word-clock period, in the clk domain |
| hold_in | input | 1 | Makes the error flag sticky when high, asynchronous |
| mute_in | input | 1 | Forces all audio channels to zero when high, asynchronous |
| src_clk | input | 1 | Clock to be gated, derived synchronously from clk |
| din | input | NCH*DW | Decoded audio channels, channel 0 in the low bits |
| err_out | output | 1 | Error flag: input absent, unlocked or not yet qualified |
| qual_ok | output | 1 | Input has been qualified by the period count |
| dout | output | NCH*DW | Audio channels after muting |
| gclk_out | output | 1 | src_clk, silenced while the error flag is set |

## Verification
The stimulus runs through three lock patterns. A lock that holds steadily shows that the flag drops at the end of the count and not before it. A lock that drops for a few cycles partway through shows that the count restarts instead of resuming. A lock lost while hold is high separates the sticky behaviour from the fault-following behaviour. Data is checked with two channel patterns under the error-only, mute-only and neither conditions, so that each of the two mute sources is seen acting alone. The gated clock's edges are counted in windows where the flag is steady, in both states.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int unsigned QUAL_DEF  = 3900;
    localparam int unsigned NCH_DEF   = 8;
    localparam int unsigned DW_DEF    = 24;
    localparam int unsigned SYNC_DEF  = 2;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_COUNT = 2'd1,
        QS_DONE  = 2'd2
    } qual_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= async_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sup_qual.sv
module sup_qual
    import sup_pkg::*;
#(
    parameter int unsigned QUAL_PERIODS = QUAL_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(QUAL_PERIODS + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_PERIODS - 1);

    typedef struct packed {
        qual_state_e st;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!lock_s) begin
            s_d.st  = QS_IDLE;
            s_d.cnt = '0;
        end else begin
            case (s_q.st)
                QS_IDLE: begin
                    s_d.st  = QS_COUNT;
                    s_d.cnt = '0;
                end
                QS_COUNT: begin
                    if (tick) begin
                        if (s_q.cnt == LAST) begin
                            s_d.st = QS_DONE;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                QS_DONE: s_d = s_q;
                default: s_d.st = QS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: QS_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done = (s_q.st == QS_DONE);
endmodule

// File: rtl/sup_clkgate.sv
module sup_clkgate (
    input  logic src_clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!src_clk) begin
            en_lat = en;
        end
    end

    assign gclk = src_clk & en_lat;
endmodule

// File: rtl/sup_err_mute.sv
module sup_err_mute
    import sup_pkg::*;
#(
    parameter int unsigned QUAL_PERIODS = QUAL_DEF,
    parameter int unsigned NCH          = NCH_DEF,
    parameter int unsigned DW           = DW_DEF,
    parameter int unsigned SYNC_STAGES  = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_in,
    input  logic              frame_tick,
    input  logic              hold_in,
    input  logic              mute_in,
    input  logic              src_clk,
    input  logic [NCH*DW-1:0] din,
    output logic              err_out,
    output logic              qual_ok,
    output logic [NCH*DW-1:0] dout,
    output logic              gclk_out
);
    localparam int unsigned TW = NCH * DW;

    logic [2:0] async_v, sync_v;
    logic       lock_s, hold_s, mute_s;
    logic       done;

    assign async_v = {mute_in, hold_in, lock_in};

    sup_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (async_v),
        .sync_out (sync_v)
    );

    assign lock_s = sync_v[0];
    assign hold_s = sync_v[1];
    assign mute_s = sync_v[2];

    sup_qual #(.QUAL_PERIODS(QUAL_PERIODS)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_s (lock_s),
        .tick   (frame_tick),
        .done   (done)
    );

    typedef struct packed {
        logic          err;
        logic [TW-1:0] data;
    } top_t;

    top_t r_d, r_q;
    logic fault;
    logic silence;
    logic [TW-1:0] masked;

    assign fault   = !done;
    assign silence = r_q.err | mute_s;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            assign masked[c*DW +: DW] = silence ? '0 : din[c*DW +: DW];
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.err  = fault | (r_q.err & hold_s);
        r_d.data = masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{err: 1'b1, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    sup_clkgate u_gate (
        .src_clk (src_clk),
        .en      (~r_q.err),
        .gclk    (gclk_out)
    );

    assign err_out = r_q.err;
    assign qual_ok = done;
    assign dout    = r_q.data;
endmodule

// File: rtl/sup_err_mute_chk.sv
module sup_err_mute_chk #(
    parameter int unsigned TW = 192
) (
    input logic          clk,
    input logic          rst_n,
    input logic          err_out,
    input logic          qual_ok,
    input logic [TW-1:0] dout,
    input logic          hold_s,
    input logic          mute_s,
    input logic          lock_s
);
    // R2: an unqualified input keeps the flag up in the next cycle
    p_unqual_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_ok |=> err_out);

    // R3: losing lock clears qualification
    p_lockdrop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s |=> !qual_ok);

    // R5: a raised flag survives while hold is high
    p_hold_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_out && hold_s) |=> err_out);

    // R6: data silent when the flag was already up a cycle earlier
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |=> (dout == '0));

    // R7: mute silences the data in the next cycle
    p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mute_s |=> (dout == '0));
endmodule

bind sup_err_mute sup_err_mute_chk #(.TW(NCH*DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_out (err_out),
    .qual_ok (qual_ok),
    .dout    (dout),
    .hold_s  (hold_s),
    .mute_s  (mute_s),
    .lock_s  (lock_s)
);

// File: tb/sim_sup_err_mute.sv
module sim_sup_err_mute;
    localparam int unsigned NCH = 8;
    localparam int unsigned DW  = 24;
    localparam int unsigned TW  = NCH * DW;
    localparam int unsigned QP  = 3900;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_in = 1'b0, hold_in = 1'b0, mute_in = 1'b0;
    logic          frame_tick = 1'b0;
    logic          src_clk = 1'b0;
    logic [TW-1:0] din = '0;
    logic          err_out, qual_ok, gclk_out;
    logic [TW-1:0] dout;

    int total = 0;
    int bad   = 0;
    int gcnt  = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        frame_tick <= ~frame_tick;
        src_clk    <= ~src_clk;
    end

    always @(posedge gclk_out) gcnt++;

    sup_err_mute u0 (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .frame_tick(frame_tick),
        .hold_in(hold_in), .mute_in(mute_in), .src_clk(src_clk), .din(din),
        .err_out(err_out), .qual_ok(qual_ok), .dout(dout), .gclk_out(gclk_out)
    );

    typedef struct {
        string         req;
        logic          err;
        logic          qual;
        logic [TW-1:0] data;
    } item_t;

    item_t sb[$];

    // monitor: pops expected items and compares against the outputs
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (err_out !== it.err || qual_ok !== it.qual || dout !== it.data) begin
                bad++;
                $display("FAIL %s: err=%b qual=%b dout=%h expected err=%b qual=%b dout=%h",
                         it.req, err_out, qual_ok, dout, it.err, it.qual, it.data);
            end
        end
    end

    task automatic expect_out(input string req, input logic e, input logic q,
                              input logic [TW-1:0] d);
        item_t it;
        it.req = req; it.err = e; it.qual = q; it.data = d;
        @(posedge clk);
        sb.push_back(it);
        @(negedge clk);
        #0.5;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_gate(input string req, input int exp_edges);
        int start;
        @(negedge clk);
        start = gcnt;
        wait_cyc(20);
        total++;
        if (gcnt - start != exp_edges) begin
            bad++;
            $display("FAIL %s: gated edges=%0d expected=%0d", req, gcnt - start, exp_edges);
        end
    endtask

    function automatic logic [TW-1:0] pattern(input int seed);
        logic [TW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*DW +: DW] = DW'(32'h5A3C00 + seed * 97 + c * 4099);
        return v;
    endfunction

    initial begin
        #(5ns * 190000);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        din = pattern(1);
        wait_cyc(4);
        expect_out("R1 reset", 1'b1, 1'b0, '0);
        rst_n = 1'b1;
        wait_cyc(3);
        expect_out("R1 after release", 1'b1, 1'b0, '0);

        // steady lock, hold low
        lock_in = 1'b1;
        wait_cyc(2 * QP - 100);
        expect_out("R2 before count ends", 1'b1, 1'b0, '0);
        expect_out("R6 data zero under error", 1'b1, 1'b0, '0);
        check_gate("R9 gate silent under error", 0);
        wait_cyc(200);
        expect_out("R2 R4 qualified, error clear", 1'b0, 1'b1, din);
        expect_out("R8 data passes", 1'b0, 1'b1, din);
        din = pattern(7);
        wait_cyc(2);
        expect_out("R8 new pattern passes", 1'b0, 1'b1, din);
        check_gate("R9 gate runs", 10);

        // mute alone
        mute_in = 1'b1;
        wait_cyc(6);
        expect_out("R7 mute zeroes data", 1'b0, 1'b1, '0);
        mute_in = 1'b0;
        wait_cyc(6);
        expect_out("R7 unmute restores data", 1'b0, 1'b1, din);

        // sticky error
        hold_in = 1'b1;
        lock_in = 1'b0;
        wait_cyc(6);
        expect_out("R3 lock loss clears qual", 1'b1, 1'b0, '0);
        lock_in = 1'b1;
        wait_cyc(2 * QP + 100);
        expect_out("R5 error held after fault clears", 1'b1, 1'b1, '0);
        check_gate("R9 gate silent while held", 0);
        hold_in = 1'b0;
        wait_cyc(6);
        expect_out("R5 release of hold clears error", 1'b0, 1'b1, din);

        // short lock loss restarts the count
        lock_in = 1'b0;
        wait_cyc(4);
        lock_in = 1'b1;
        wait_cyc(2 * QP - 600);
        expect_out("R3 count restarted", 1'b1, 1'b0, '0);
        wait_cyc(800);
        expect_out("R3 R4 requalified", 1'b0, 1'b1, din);

        wait_cyc(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule